// File: doc/BRIEF.md
# Reset Cause Recorder and Timed Soft-Reset Unit

This block keeps a two-bit record of what caused the most recent device reset and shows it to software as a read-only field of a 16-bit configuration register. An active-low external reset input loads one code when the debug-reset-enable input is low and a different code when it is high. A one-cycle watchdog timeout event loads a third code. Code 00 is never produced.

The same register holds a self-clearing soft-reset bit. Writing a one to it drives two active-low outputs for a fixed number of clock cycles: the peripheral reset line and the reset-out pin. The processor is not reset. A third active-low output feeds the modules that the soft reset must leave alone: chip select, interrupt controller, GPIO and SDRAM controller. That output follows only the hardware reset. While the pulse runs, the bit reads back as one, and it clears on its own when the pulse ends.

Top module: `rst_cause_ctl`

## Requirements
- R1: While `ext_rst_n` is low and `dbg_rst_en` is low, the cause field (read data bits 13:12) is loaded with 01, visible once reset is released.
- R2: While `ext_rst_n` is low and `dbg_rst_en` is high, the cause field is loaded with 11.
- R3: A high `wdt_expire` with `ext_rst_n` high loads cause 10, readable the cycle after. If the external reset is low in the same cycle, the external reset code wins.
- R4: The cause field is read-only. Register writes leave it unchanged, a soft reset leaves it unchanged, and it never reads 00 after the first hardware reset.
- R5: Read data bit 15 is always 1 and bit 14 is always 0. Every bit other than 15, 13:12 and 6 reads 0, and writing any of these bits has no effect.
- R6: A write with data bit 6 set drives `periph_rst_n` and `rst_out_n` low from the cycle after the write, for exactly 128 clock cycles.
- R7: `keep_rst_n` is not affected by the soft reset and equals `ext_rst_n`.
- R8: Read data bit 6 reads 1 while the soft-reset pulse is active and returns to 0 on its own when the pulse ends.
- R9: A write during an active pulse does not restart or shorten it, whether bit 6 is 1 or 0. A watchdog event during the pulse does not alter its length.
- R10: A low `ext_rst_n` holds all three reset outputs low, ends any soft-reset pulse, and leaves bit 6 reading 0 after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| ext_rst_n | input | 1 | External hardware reset, active low, sampled on the clock |
| dbg_rst_en | input | 1 | Debug reset enable, qualifies the recorded external reset code |
| wdt_expire | input | 1 | Watchdog timeout event, one cycle high |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| periph_rst_n | output | 1 | Reset to the peripheral group, active low |
| rst_out_n | output | 1 | Reset-out pin, active low |
| keep_rst_n | output | 1 | Reset to the modules excluded from the soft reset, active low |

## Verification
The assertions check four things on every cycle. The cause never holds the reserved code after reset. A watchdog event lands as code 10. The cause holds still in every other cycle. A pulse always ends with its counter at the last step and never restarts on a second write. Only the bench's scenarios show the remaining behaviours. These are the exact 128-cycle length measured at the output pins against writes at many offsets into the pulse, the two external-reset codes under each debug-enable level, and the read-back of the fixed and read-only bits after write patterns across the whole word. They also include the early end of a pulse by a hardware reset.

// File: rtl/rst_cause_pkg.sv
package rst_cause_pkg;

    typedef enum logic [1:0] {
        CAUSE_RSVD    = 2'b00,
        CAUSE_PIN     = 2'b01,
        CAUSE_WDT     = 2'b10,
        CAUSE_PIN_DBG = 2'b11
    } cause_e;

endpackage

// File: rtl/rst_cause_rec.sv
module rst_cause_rec
    import rst_cause_pkg::*;
(
    input  logic   clk,
    input  logic   ext_rst_n,
    input  logic   dbg_rst_en,
    input  logic   wdt_expire,
    output cause_e cause
);

    typedef struct packed {
        cause_e code;
    } rec_t;

    rec_t rec_d, rec_q;

    always_comb begin
        rec_d = rec_q;
        if (!ext_rst_n) begin
            rec_d.code = dbg_rst_en ? CAUSE_PIN_DBG : CAUSE_PIN;
        end else if (wdt_expire) begin
            rec_d.code = CAUSE_WDT;
        end
    end

    always_ff @(posedge clk) begin
        rec_q <= rec_d;
    end

    assign cause = rec_q.code;

    // R4
    never_rsvd_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
        rec_q.code != CAUSE_RSVD);

    // R3
    wdt_load_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
        wdt_expire |=> rec_q.code == CAUSE_WDT);

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
        !wdt_expire |=> $stable(rec_q.code));

endmodule

// File: rtl/rst_pulse_timer.sv
module rst_pulse_timer #(
    parameter int PULSE_LEN = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active
);

    localparam int CNT_W = (PULSE_LEN > 2) ? $clog2(PULSE_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSE_LEN - 1);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.active) begin
            if (tmr_q.cnt == LAST) begin
                tmr_d.active = 1'b0;
                tmr_d.cnt    = '0;
            end else begin
                tmr_d.cnt = tmr_q.cnt + 1'b1;
            end
        end else if (start) begin
            tmr_d.active = 1'b1;
            tmr_d.cnt    = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign active = tmr_q.active;

    // R6
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tmr_q.active) |-> $past(tmr_q.cnt) == LAST);

    // R9
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_q.active && start && tmr_q.cnt != LAST)
        |=> tmr_q.active && tmr_q.cnt == CNT_W'($past(tmr_q.cnt) + 1'b1));

endmodule

// File: rtl/rst_cause_ctl.sv
module rst_cause_ctl
    import rst_cause_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int PULSE_LEN = 128
) (
    input  logic              clk,
    input  logic              ext_rst_n,
    input  logic              dbg_rst_en,
    input  logic              wdt_expire,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              periph_rst_n,
    output logic              rst_out_n,
    output logic              keep_rst_n
);

    localparam int ONE_BIT   = DATA_W - 1;
    localparam int CAUSE_LSB = DATA_W - 4;
    localparam int SOFT_BIT  = 6;

    cause_e cause;
    logic   soft_start;
    logic   soft_active;

    rst_cause_rec i_rec (
        .clk        (clk),
        .ext_rst_n  (ext_rst_n),
        .dbg_rst_en (dbg_rst_en),
        .wdt_expire (wdt_expire),
        .cause      (cause)
    );

    assign soft_start = reg_wr && reg_wdata[SOFT_BIT] && ext_rst_n;

    rst_pulse_timer #(.PULSE_LEN(PULSE_LEN)) i_tmr (
        .clk    (clk),
        .rst_n  (ext_rst_n),
        .start  (soft_start),
        .active (soft_active)
    );

    always_comb begin
        reg_rdata                       = '0;
        reg_rdata[ONE_BIT]              = 1'b1;
        reg_rdata[CAUSE_LSB +: 2]       = cause;
        reg_rdata[SOFT_BIT]             = soft_active;
    end

    assign periph_rst_n = ext_rst_n && !soft_active;
    assign rst_out_n    = ext_rst_n && !soft_active;
    assign keep_rst_n   = ext_rst_n;

    // R7
    keep_rst_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
        soft_active |-> keep_rst_n && !periph_rst_n && !rst_out_n);

endmodule

// File: tb/test_rst_cause_ctl.sv
module test_rst_cause_ctl;

    logic        clk = 1'b0;
    logic        ext_rst_n = 1'b0;
    logic        dbg_rst_en = 1'b0;
    logic        wdt_expire = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        periph_rst_n, rst_out_n, keep_rst_n;

    int n_chk = 0;
    int n_fail = 0;
    int low_cnt = 0;
    int pin_mis = 0;
    bit done = 0;

    always #5 clk = ~clk;

    rst_cause_ctl i_rst_cause_ctl (
        .clk(clk), .ext_rst_n(ext_rst_n), .dbg_rst_en(dbg_rst_en),
        .wdt_expire(wdt_expire), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .periph_rst_n(periph_rst_n),
        .rst_out_n(rst_out_n), .keep_rst_n(keep_rst_n)
    );

    always @(negedge clk) begin
        if (ext_rst_n && !periph_rst_n) low_cnt++;
        if (periph_rst_n != rst_out_n) pin_mis++;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hw_reset(input bit dbg);
        @(negedge clk);
        ext_rst_n = 1'b0; dbg_rst_en = dbg;
        repeat (3) @(negedge clk);
        chk(!keep_rst_n && !periph_rst_n && !rst_out_n, "R10 outputs low in reset",
            {keep_rst_n, periph_rst_n, rst_out_n}, 0);
        ext_rst_n = 1'b1; dbg_rst_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_write(input logic [15:0] d);
        reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    initial begin
        repeat (150000) @(negedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] exp_rd;
        // reset state with debug enable low
        repeat (2) @(negedge clk);
        ext_rst_n = 1'b1;
        hw_reset(1'b0);
        chk(reg_rdata == 16'h9000, "R1 cause 01 after pin reset", reg_rdata, 16'h9000);
        chk(keep_rst_n && periph_rst_n && rst_out_n, "R7 outputs released", 0, 1);
        hw_reset(1'b1);
        chk(reg_rdata[13:12] == 2'b11, "R2 cause 11 with debug enable", reg_rdata[13:12], 3);
        hw_reset(1'b0);
        chk(reg_rdata[13:12] == 2'b01, "R1 cause 01 again", reg_rdata[13:12], 1);

        // watchdog event
        wdt_expire = 1'b1;
        @(negedge clk);
        wdt_expire = 1'b0;
        chk(reg_rdata[13:12] == 2'b10, "R3 watchdog cause 10", reg_rdata[13:12], 2);
        // simultaneous watchdog and pin reset: pin wins
        ext_rst_n = 1'b0; dbg_rst_en = 1'b1; wdt_expire = 1'b1;
        @(negedge clk);
        wdt_expire = 1'b0; ext_rst_n = 1'b1; dbg_rst_en = 1'b0;
        @(negedge clk);
        chk(reg_rdata[13:12] == 2'b11, "R3 pin reset beats watchdog", reg_rdata[13:12], 3);

        // sweep write patterns with soft bit clear: readback unchanged
        for (int i = 0; i < 64; i++) begin
            logic [15:0] pat;
            pat = (16'(i) * 16'h0411) ^ 16'hA5C3;
            pat[6] = 1'b0;
            do_write(pat);
            exp_rd = 16'h8000 | (16'h3 << 12);
            chk(reg_rdata == exp_rd && periph_rst_n, "R5 R4 write of fixed/read-only bits",
                reg_rdata, exp_rd);
        end

        // soft reset pulses, rewrite at many offsets
        for (int k = 0; k < 140; k += 7) begin
            logic [15:0] rw;
            rw = (k % 3 == 0) ? 16'h0040 : ((k % 3 == 1) ? 16'h0000 : 16'hFFFF);
            @(negedge clk);
            low_cnt = 0; pin_mis = 0;
            do_write(16'h0040);
            chk(!periph_rst_n && !rst_out_n && keep_rst_n, "R6 R7 pulse starts next cycle",
                {periph_rst_n, rst_out_n, keep_rst_n}, 1);
            chk(reg_rdata[6] == 1'b1, "R8 soft bit reads 1 while active", reg_rdata[6], 1);
            repeat (k) @(negedge clk);
            if (k == 21) wdt_expire = 1'b1;
            do_write(rw);
            wdt_expire = 1'b0;
            repeat (200) @(negedge clk);
            chk(low_cnt == 128, "R6 R9 pulse length 128", low_cnt, 128);
            chk(pin_mis == 0, "R6 reset-out matches peripheral reset", pin_mis, 0);
            chk(reg_rdata[6] == 1'b0, "R8 soft bit self-clears", reg_rdata[6], 0);
            exp_rd = (k == 21) ? 16'hA000 : 16'hB000;
            chk(reg_rdata == exp_rd, "R4 cause kept through soft reset", reg_rdata, exp_rd);
            if (k == 21) hw_reset(1'b1);
        end

        // hardware reset ends a pulse early
        do_write(16'h0040);
        repeat (20) @(negedge clk);
        hw_reset(1'b0);
        chk(periph_rst_n && rst_out_n && keep_rst_n, "R10 pulse ended by pin reset",
            {periph_rst_n, rst_out_n, keep_rst_n}, 7);
        chk(reg_rdata == 16'h9000, "R10 soft bit 0 after pin reset", reg_rdata, 16'h9000);
        repeat (150) @(negedge clk);
        chk(periph_rst_n, "R10 no pulse resumes", periph_rst_n, 1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule